// File: doc/BRIEF.md
# Constant-Latency Context-Switch Flush Sequencer

This block sits inside a processor core and runs each time a context-switch fence instruction retires. It clears the microarchitectural state that could carry information from one software context to the next. It asks the L1 data cache, the instruction cache and the TLB to flush, one after another. Each structure answers on its own handshake. Once all three have answered, the block sends a one-cycle reset strobe to the core's internal state machines.

The completion pulse never arrives earlier than a fixed count of cycles after the start. This holds however quickly the structures respond. The switch therefore takes the same time whether the caches held many dirty lines or none, and its duration cannot encode earlier activity.

The pad is the parameter `PAD_CYCLES`, default 300. It must stay below 320 cycles and must be at least 4. If a structure has still not answered when the pad expires, the block raises a sticky error flag. It then waits for the late answer and finishes as soon as the sequence is complete.

Each flush handshake is a request level and an acknowledge pulse. The request stays high until the acknowledge is sampled. The acknowledge is meaningful only while its own request is high. The block applies no back-pressure of its own.

Top module: `tfence_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fsm_rst_o`, `overrun_o` and all three flush requests are low.
- R2: A `start_i` sampled high while idle makes `busy_o` high in the next cycle (cycle 0 of the operation), with `dc_flush_req_o` high in that same cycle.
- R3: Flushes run in the fixed order data cache, instruction cache, TLB. At most one request is high at a time, and each request stays high until its acknowledge is sampled.
- R4: `fsm_rst_o` is high for exactly one cycle: the cycle directly after the cycle in which the TLB acknowledge was sampled.
- R5: When the three flushes and the strobe finish before cycle `PAD_CYCLES`, `done_o` is high in cycle `PAD_CYCLES` of the operation, whatever the acknowledge latencies.
- R6: `done_o` is a single-cycle pulse. `busy_o` is high from cycle 0 through the done cycle and low in the cycle after it.
- R7: `start_i` is ignored while `busy_o` is high, including in the done cycle. No second operation starts and no extra done pulse appears.
- R8: If the sequence (flushes or strobe) is unfinished in cycle `PAD_CYCLES`, `overrun_o` goes high and stays high until reset. `done_o` then comes two cycles after the cycle of the late TLB acknowledge.
- R9: A flush acknowledge whose request is low has no effect. While idle, such pulses leave `busy_o`, `fsm_rst_o` and every request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Fence retired; starts a flush operation when idle |
| dc_flush_req_o | output | 1 | Data cache flush request |
| dc_flush_ack_i | input | 1 | Data cache flush acknowledge pulse |
| ic_flush_req_o | output | 1 | Instruction cache flush request |
| ic_flush_ack_i | input | 1 | Instruction cache flush acknowledge pulse |
| tlb_flush_req_o | output | 1 | TLB flush request |
| tlb_flush_ack_i | input | 1 | TLB flush acknowledge pulse |
| fsm_rst_o | output | 1 | One-cycle reset strobe to internal state machines |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| overrun_o | output | 1 | Sticky flag: sequence outlasted the pad |

## Verification
Two functions can coincide in one cycle.

The first pair is the pad expiry and the end of the flush sequence. The bench sets the TLB responder's latency so that its acknowledge lands two cycles before the limit, which must still give an on-time done with no error flag. It then sets it one cycle later, so that the strobe falls on the limit cycle, which must raise the flag and move done one cycle later.

The second pair is a new start and the done pulse. The bench drives `start_i` in exactly the done cycle. It expects the request to be ignored: busy drops, no request rises, and no second done appears.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
  localparam int unsigned N_TGT   = 3;
  localparam int unsigned TGT_DC  = 0;
  localparam int unsigned TGT_IC  = 1;
  localparam int unsigned TGT_TLB = 2;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FLUSH  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } tfs_phase_e;
endpackage

// File: rtl/tfs_flush_chain.sv
// Walks a fixed list of flush targets in index order, one request at a time.
module tfs_flush_chain #(
  parameter int unsigned NT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick_i,
  input  logic [NT-1:0] ack_i,
  output logic [NT-1:0] req_o,
  output logic          last_ack_o
);
  localparam int unsigned IDXW = (NT > 1) ? $clog2(NT) : 1;

  logic [IDXW-1:0] idx_q;
  logic            active_q;
  logic [NT-1:0]   hit;
  logic            cur_ack;

  for (genvar g = 0; g < NT; g++) begin : g_slot
    assign req_o[g] = active_q && (idx_q == IDXW'(g));
    assign hit[g]   = req_o[g] & ack_i[g];
  end

  assign cur_ack    = |hit;
  assign last_ack_o = hit[NT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (kick_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q && cur_ack) begin
      if (idx_q == IDXW'(NT - 1)) begin
        active_q <= 1'b0;
      end else begin
        idx_q <= IDXW'(idx_q + 1'b1);
      end
    end
  end
endmodule

// File: rtl/tfs_pad_counter.sv
// Counts cycles from the start of an operation and saturates at LIMIT.
module tfs_pad_counter #(
  parameter int unsigned LIMIT = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic at_limit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (run_i && (cnt_q != CW'(LIMIT))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign at_limit_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/tfence_seq.sv
module tfence_seq #(
  parameter int unsigned PAD_CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic dc_flush_req_o,
  input  logic dc_flush_ack_i,
  output logic ic_flush_req_o,
  input  logic ic_flush_ack_i,
  output logic tlb_flush_req_o,
  input  logic tlb_flush_ack_i,
  output logic fsm_rst_o,
  output logic busy_o,
  output logic done_o,
  output logic overrun_o
);
  import tfs_pkg::*;

  tfs_phase_e       phase_q, phase_d;
  logic             accept;
  logic             last_ack;
  logic             at_limit;
  logic             overrun_q;
  logic [N_TGT-1:0] ack_v;
  logic [N_TGT-1:0] req_v;

  assign ack_v[TGT_DC]  = dc_flush_ack_i;
  assign ack_v[TGT_IC]  = ic_flush_ack_i;
  assign ack_v[TGT_TLB] = tlb_flush_ack_i;

  assign dc_flush_req_o  = req_v[TGT_DC];
  assign ic_flush_req_o  = req_v[TGT_IC];
  assign tlb_flush_req_o = req_v[TGT_TLB];

  assign accept = (phase_q == PH_IDLE) && start_i;

  tfs_flush_chain #(.NT(N_TGT)) chain_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .kick_i     (accept),
    .ack_i      (ack_v),
    .req_o      (req_v),
    .last_ack_o (last_ack)
  );

  tfs_pad_counter #(.LIMIT(PAD_CYCLES)) pad_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (accept),
    .run_i      (busy_o),
    .at_limit_o (at_limit)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (accept)   phase_d = PH_FLUSH;
      PH_FLUSH:  if (last_ack) phase_d = PH_STROBE;
      PH_STROBE:               phase_d = PH_HOLD;
      PH_HOLD:   if (at_limit) phase_d = PH_IDLE;
      default:                 phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      overrun_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (at_limit && ((phase_q == PH_FLUSH) || (phase_q == PH_STROBE))) begin
        overrun_q <= 1'b1;
      end
    end
  end

  assign busy_o    = (phase_q != PH_IDLE);
  assign fsm_rst_o = (phase_q == PH_STROBE);
  assign done_o    = (phase_q == PH_HOLD) && at_limit;
  assign overrun_o = overrun_q;
endmodule

// File: rtl/tfs_chk.sv
module tfs_chk #(
  parameter int unsigned PAD_CYCLES = 300
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic dc_flush_req_o,
  input logic dc_flush_ack_i,
  input logic ic_flush_req_o,
  input logic ic_flush_ack_i,
  input logic tlb_flush_req_o,
  input logic tlb_flush_ack_i,
  input logic fsm_rst_o,
  input logic busy_o,
  input logic done_o,
  input logic overrun_o
);
  logic [15:0] ck_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_cnt <= '0;
    end else if (!busy_o && start_i) begin
      ck_cnt <= '0;
    end else if (busy_o && (ck_cnt < 16'(PAD_CYCLES))) begin
      ck_cnt <= ck_cnt + 1'b1;
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && dc_flush_req_o));

  p_onehot_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dc_flush_req_o, ic_flush_req_o, tlb_flush_req_o}));

  p_dc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_flush_req_o && !dc_flush_ack_i) |=> dc_flush_req_o);

  p_ic_after_dc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ic_flush_req_o) |-> $past(dc_flush_req_o && dc_flush_ack_i));

  p_tlb_after_ic_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tlb_flush_req_o) |-> $past(ic_flush_req_o && ic_flush_ack_i));

  p_strobe_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_rst_o |-> $past(tlb_flush_req_o && tlb_flush_ack_i));

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_rst_o |=> !fsm_rst_o);

  p_fixed_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !overrun_o) |-> (ck_cnt == 16'(PAD_CYCLES)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  p_done_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(dc_flush_req_o || ic_flush_req_o || tlb_flush_req_o || fsm_rst_o));
endmodule

bind tfence_seq tfs_chk #(.PAD_CYCLES(PAD_CYCLES)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .dc_flush_req_o  (dc_flush_req_o),
  .dc_flush_ack_i  (dc_flush_ack_i),
  .ic_flush_req_o  (ic_flush_req_o),
  .ic_flush_ack_i  (ic_flush_ack_i),
  .tlb_flush_req_o (tlb_flush_req_o),
  .tlb_flush_ack_i (tlb_flush_ack_i),
  .fsm_rst_o       (fsm_rst_o),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .overrun_o       (overrun_o)
);

// File: tb/tfence_seq_tb_top.sv
`timescale 1ns/1ps
module tfence_seq_tb_top;
  localparam int PAD = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] ack = 3'b000;
  logic dc_req, ic_req, tlb_req, fsm_rst, busy, done, overrun;
  logic [2:0] reqv;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  int lat [3];
  logic [2:0] stray = 3'b000;
  int wcnt [3];

  int t0 = 0;
  int first_req [3];
  int ack_cyc [3];
  int strobe_cyc = 0;
  int strobe_cnt = 0;
  int done_cyc = 0;
  int done_cnt = 0;
  int multi_req = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign reqv = {tlb_req, ic_req, dc_req};

  tfence_seq #(.PAD_CYCLES(PAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dc_flush_req_o(dc_req),   .dc_flush_ack_i(ack[0]),
    .ic_flush_req_o(ic_req),   .ic_flush_ack_i(ack[1]),
    .tlb_flush_req_o(tlb_req), .tlb_flush_ack_i(ack[2]),
    .fsm_rst_o(fsm_rst), .busy_o(busy), .done_o(done), .overrun_o(overrun)
  );

  // Responders and monitor, both acting on the falling edge.
  initial begin
    for (int t = 0; t < 3; t++) begin
      wcnt[t] = 0; first_req[t] = -1; ack_cyc[t] = -1; lat[t] = 0;
    end
    forever begin
      @(negedge clk);
      if (rst_n && start_i && !busy) begin
        t0 = cyc + 1;
        strobe_cnt = 0;
        for (int t = 0; t < 3; t++) first_req[t] = -1;
      end
      for (int t = 0; t < 3; t++) begin
        if (reqv[t] && first_req[t] < 0) first_req[t] = cyc;
      end
      if (fsm_rst) begin strobe_cyc = cyc; strobe_cnt++; end
      if (done) begin done_cyc = cyc; done_cnt++; end
      if ($countones(reqv) > 1) multi_req++;
      for (int t = 0; t < 3; t++) begin
        ack[t] = stray[t];
        if (reqv[t]) begin
          if (wcnt[t] == lat[t]) begin
            ack[t] = 1'b1; ack_cyc[t] = cyc; wcnt[t] = 0;
          end else begin
            wcnt[t]++;
          end
        end else begin
          wcnt[t] = 0;
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic wait_done(input int prev);
    int guard = 0;
    while (done_cnt == prev && guard < 2000) begin tick(); guard++; end
  endtask

  task automatic t_reset();
    check({busy, done, fsm_rst, overrun, reqv} == 7'd0, "R1 reset outputs",
          int'({busy, done, fsm_rst, overrun, reqv}), 0);
  endtask

  task automatic t_normal(input int l0, input int l1, input int l2, input string name);
    int prev = done_cnt;
    lat[0] = l0; lat[1] = l1; lat[2] = l2;
    pulse_start();
    check(busy == 1'b1 && dc_req == 1'b1, {"R2 busy and dc req in cycle 0 ", name}, int'({busy, dc_req}), 3);
    wait_done(prev);
    check(first_req[0] == t0, {"R2 dc req cycle ", name}, first_req[0], t0);
    check(first_req[0] < first_req[1] && first_req[1] < first_req[2],
          {"R3 order ic after dc, tlb after ic ", name}, first_req[2], first_req[1] + 1);
    check(strobe_cnt == 1 && strobe_cyc == ack_cyc[2] + 1, {"R4 strobe after tlb ack ", name},
          strobe_cyc, ack_cyc[2] + 1);
    check(done_cyc - t0 == PAD, {"R5 fixed done latency ", name}, done_cyc - t0, PAD);
    check(busy == 1'b0 && done == 1'b0 && done_cnt == prev + 1, {"R6 single done then idle ", name},
          int'({busy, done}), 0);
  endtask

  task automatic t_busy_start();
    int prev = done_cnt;
    int first_t0;
    lat[0] = 2; lat[1] = 3; lat[2] = 1;
    pulse_start();
    first_t0 = t0;
    repeat (6) tick();
    pulse_start();
    while (cyc < first_t0 + PAD) tick();
    check(done == 1'b1, "R7 done cycle reached", int'(done), 1);
    start_i = 1'b1; tick(); start_i = 1'b0;
    repeat (3) tick();
    check(busy == 1'b0 && reqv == 3'b000, "R7 start in done cycle ignored", int'({busy, reqv}), 0);
    check(done_cnt == prev + 1 && done_cyc - first_t0 == PAD, "R7 one done at original time",
          done_cyc - first_t0, PAD);
  endtask

  task automatic t_stray();
    int s0 = strobe_cnt;
    stray = 3'b111; repeat (2) tick(); stray = 3'b000; tick();
    check(busy == 1'b0 && reqv == 3'b000 && strobe_cnt == s0, "R9 stray acks ignored",
          int'({busy, reqv}), 0);
  endtask

  task automatic t_edge_on_time();
    int prev = done_cnt;
    lat[0] = 0; lat[1] = 0; lat[2] = PAD - 4;
    pulse_start();
    wait_done(prev);
    check(ack_cyc[2] - t0 == PAD - 2, "R5 tlb ack two before limit", ack_cyc[2] - t0, PAD - 2);
    check(done_cyc - t0 == PAD && overrun == 1'b0, "R5 on-time done, no flag", done_cyc - t0, PAD);
  endtask

  task automatic t_overrun(input int l2, input string name);
    int prev = done_cnt;
    lat[0] = 0; lat[1] = 0; lat[2] = l2;
    pulse_start();
    wait_done(prev);
    check(overrun == 1'b1, {"R8 overrun flag ", name}, int'(overrun), 1);
    check(done_cyc == ack_cyc[2] + 2, {"R8 done after late ack ", name}, done_cyc, ack_cyc[2] + 2);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (completion)");
    $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_normal(0, 0, 0, "fast");
    t_normal(9, 12, 7, "slow");
    t_normal(3, 0, 15, "mixed");
    check(multi_req == 0, "R3 one request at a time", multi_req, 0);
    t_busy_start();
    t_stray();
    t_normal(1, 1, 1, "after stray");
    t_edge_on_time();
    t_overrun(PAD - 3, "strobe at limit");
    t_overrun(PAD + 10, "ack beyond limit");
    t_normal(2, 2, 2, "sticky");
    check(overrun == 1'b1, "R8 flag sticky across ops", int'(overrun), 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule